// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the bus address for one DMA channel (source or target) on every transfer beat. A load pulse captures a 24-bit channel address word, a megabyte selector, a mode bit and a signed 8.8 step. The block then holds a fixed-point offset with eight fractional bits and a latched megabyte base. Each completed beat adds the step to the offset. The integer part of the offset wraps inside a 1 MiB slice and never carries into the base.

Each access is steered to I/O space or to memory space. This is decided per access: the top bit of the loaded address word enables I/O, but only addresses whose bits 15:12 are hex D go to I/O. Every other address still goes to memory. Write strobes are dropped when the data byte equals a transparency value, and this comparison can be switched off.

The controller has two states. IDLE is the state after reset, and in it beats are ignored. ACTIVE is reached through the transition LOAD, taken from either state whenever `load` is high. In ACTIVE the transition ADVANCE, a beat without a load, steps the offset. Only reset returns the block to IDLE.

Top module: `dma_chan_addr`

## Requirements
- R1: After reset, `active`, `io_sel`, `rd_stb` and `wr_en` are 0 and `addr` is 0.
- R2: A cycle with `load` high moves the block to ACTIVE. From the next clock edge, `addr` equals the base plus `ld_addr[19:0]`, and the fractional offset is cleared.
- R3: With `ld_enh` low at load, the base is `ld_mbyte` << 20, and `ld_addr[22:20]` has no effect.
- R4: With `ld_enh` high at load, the base is ((`ld_mbyte` << 20) + (`ld_addr[22:20]` << 20)) truncated to 28 bits, with bits 19:0 zero.
- R5: Each beat in ACTIVE without a load adds the signed step {`ld_step_int`,`ld_step_frac`} captured at load to the offset. The step is in 1/256-byte units, and `addr` shows the new value one edge later. A step of 0x0080 therefore advances the address by one byte every two beats.
- R6: A step of zero leaves `addr` unchanged across beats.
- R7: A negative step below offset 0 wraps the integer part to 0xFFFFF inside the slice; address bits 27:20 are unchanged.
- R8: A positive step past integer offset 0xFFFFF wraps to 0 inside the slice; address bits 27:20 are unchanged.
- R9: `io_sel` is 1 only when ACTIVE, `ld_addr[23]` was 1 at load and `addr[15:12]` is 0xD.
- R10: `wr_en` is 0 on a write beat whose `wdata` equals `tp_val` while `tp_en` is 1. With `tp_en` 0, or with different data, a write beat in ACTIVE gives `wr_en` 1.
- R11: In IDLE, beats give no strobes and do not change `addr`.
- R12: In ACTIVE, `rd_stb` equals `beat` and not `beat_wr` in the same cycle, and `wr_en` is never 1 on a read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture channel setup; takes priority over a beat |
| ld_addr | input | 24 | Channel address word: bit 23 I/O enable, 22:20 extra megabyte bits, 19:0 offset |
| ld_mbyte | input | 8 | Megabyte selector |
| ld_enh | input | 1 | Enhanced base mode (adds ld_addr[22:20]) |
| ld_step_int | input | 8 | Step integer byte (signed as the top of a 16-bit word) |
| ld_step_frac | input | 8 | Step fractional byte |
| beat | input | 1 | A transfer beat completes this cycle |
| beat_wr | input | 1 | The beat is a write |
| wdata | input | 8 | Write data byte of the beat |
| tp_en | input | 1 | Enable transparency compare |
| tp_val | input | 8 | Transparency byte |
| addr | output | 28 | Effective byte address |
| io_sel | output | 1 | 1 selects I/O space, 0 memory |
| rd_stb | output | 1 | Read strobe |
| wr_en | output | 1 | Gated write enable |
| active | output | 1 | Block is in ACTIVE |

## Verification
Strobes and `io_sel` follow the inputs and the present address in the same cycle. `addr` and `active` change on the first clock edge after a load or beat, so they are due one cycle after the stimulus. The driver applies each stimulus on a falling edge and checks the strobes one nanosecond later. It pushes the expected address, I/O select and state into a queue. The monitor pops that entry two nanoseconds after the following rising edge, so every address result is compared exactly one register stage after its stimulus.

// File: rtl/dma_chan_addr_pkg.sv
package dma_chan_addr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } chan_state_t;
endpackage

// File: rtl/dma_chan_base.sv
module dma_chan_base #(
    parameter int SLICE_W = 20,
    parameter int MB_W    = 8,
    parameter int XB_W    = 3
) (
    input  logic [MB_W-1:0]         mbyte,
    input  logic [XB_W-1:0]         xbits,
    input  logic                    enh,
    output logic [MB_W+SLICE_W-1:0] base
);
    localparam int ADDR_W = MB_W + SLICE_W;

    logic [ADDR_W-1:0] base_def;
    logic [ADDR_W-1:0] base_sum;

    always_comb begin
        base_def = {mbyte, {SLICE_W{1'b0}}};
        base_sum = base_def + {{(ADDR_W-SLICE_W-XB_W){1'b0}}, xbits, {SLICE_W{1'b0}}};
        base     = enh ? {base_sum[ADDR_W-1:SLICE_W], {SLICE_W{1'b0}}} : base_def;
    end
endmodule

// File: rtl/dma_chan_steer.sv
module dma_chan_steer #(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8,
    parameter int WIN_LO = 12,
    parameter int WIN_W  = 4,
    parameter logic [WIN_W-1:0] WIN_VAL = 4'hD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              io_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              beat,
    input  logic              beat_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tp_en,
    input  logic [DATA_W-1:0] tp_val,
    output logic              io_sel,
    output logic              rd_stb,
    output logic              wr_en
);
    logic in_window;
    logic tp_hit;

    always_comb begin
        in_window = (addr[WIN_LO+WIN_W-1:WIN_LO] == WIN_VAL);
        tp_hit    = tp_en && (wdata == tp_val);
        io_sel    = active && io_en && in_window;
        rd_stb    = active && beat && !beat_wr;
        wr_en     = active && beat && beat_wr && !tp_hit;
    end

    assert_tp_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_en && wdata == tp_val) |-> !wr_en);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!rd_stb && !wr_en && !io_sel));
    assert_rw_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_en));
endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
    import dma_chan_addr_pkg::*;
#(
    parameter int SLICE_W = 20,
    parameter int FRAC_W  = 8,
    parameter int MB_W    = 8,
    parameter int LIST_W  = 24,
    parameter int STEP_IW = 8,
    parameter int DATA_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LIST_W-1:0]       ld_addr,
    input  logic [MB_W-1:0]         ld_mbyte,
    input  logic                    ld_enh,
    input  logic [STEP_IW-1:0]      ld_step_int,
    input  logic [FRAC_W-1:0]       ld_step_frac,
    input  logic                    beat,
    input  logic                    beat_wr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    tp_en,
    input  logic [DATA_W-1:0]       tp_val,
    output logic [MB_W+SLICE_W-1:0] addr,
    output logic                    io_sel,
    output logic                    rd_stb,
    output logic                    wr_en,
    output logic                    active
);
    localparam int ADDR_W = MB_W + SLICE_W;
    localparam int OFF_W  = SLICE_W + FRAC_W;
    localparam int STEP_W = STEP_IW + FRAC_W;
    localparam int XB_W   = LIST_W - 1 - SLICE_W;

    chan_state_t           state_q, state_d;
    logic [OFF_W-1:0]      off_q;
    logic [ADDR_W-1:0]     base_q;
    logic [STEP_W-1:0]     step_q;
    logic                  io_en_q;
    logic [ADDR_W-1:0]     base_new;
    logic                  advance;
    logic [OFF_W-1:0]      step_ext;

    dma_chan_base #(.SLICE_W(SLICE_W), .MB_W(MB_W), .XB_W(XB_W)) i_base (
        .mbyte (ld_mbyte),
        .xbits (ld_addr[LIST_W-2:SLICE_W]),
        .enh   (ld_enh),
        .base  (base_new)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_ACTIVE;
            ST_ACTIVE: state_d = ST_ACTIVE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        advance  = (state_q == ST_ACTIVE) && beat && !load;
        step_ext = {{(OFF_W-STEP_W){step_q[STEP_W-1]}}, step_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            base_q  <= '0;
            step_q  <= '0;
            io_en_q <= 1'b0;
        end else if (load) begin
            off_q   <= {ld_addr[SLICE_W-1:0], {FRAC_W{1'b0}}};
            base_q  <= base_new;
            step_q  <= {ld_step_int, ld_step_frac};
            io_en_q <= ld_addr[LIST_W-1];
        end else if (advance) begin
            off_q   <= off_q + step_ext;
        end
    end

    always_comb begin
        active = (state_q == ST_ACTIVE);
        addr   = {base_q[ADDR_W-1:SLICE_W], off_q[OFF_W-1:FRAC_W]};
    end

    dma_chan_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .io_en   (io_en_q),
        .addr    (addr),
        .beat    (beat),
        .beat_wr (beat_wr),
        .wdata   (wdata),
        .tp_en   (tp_en),
        .tp_val  (tp_val),
        .io_sel  (io_sel),
        .rd_stb  (rd_stb),
        .wr_en   (wr_en)
    );

    assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);
    assert_zero_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && beat && !load && step_q == '0) |=> $stable(addr));
    assert_slice_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load) |=> $stable(addr[ADDR_W-1:SLICE_W]));
    assert_io_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (addr[15:12] == 4'hD && active));
endmodule

// File: tb/test_dma_chan_addr.sv
module test_dma_chan_addr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [23:0] ld_addr = '0;
    logic [7:0]  ld_mbyte = '0;
    logic        ld_enh = 1'b0;
    logic [7:0]  ld_step_int = '0;
    logic [7:0]  ld_step_frac = '0;
    logic        beat = 1'b0;
    logic        beat_wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic        tp_en = 1'b0;
    logic [7:0]  tp_val = '0;
    logic [27:0] addr;
    logic        io_sel, rd_stb, wr_en, active;

    always #4 clk = ~clk;

    dma_chan_addr i_dma_chan_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr), .ld_mbyte(ld_mbyte),
        .ld_enh(ld_enh), .ld_step_int(ld_step_int), .ld_step_frac(ld_step_frac),
        .beat(beat), .beat_wr(beat_wr), .wdata(wdata), .tp_en(tp_en), .tp_val(tp_val),
        .addr(addr), .io_sel(io_sel), .rd_stb(rd_stb), .wr_en(wr_en), .active(active)
    );

    typedef struct {
        logic [27:0] a;
        logic        io;
        logic        act;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;

    logic [27:0] m_off = '0;
    logic [27:0] m_base = '0;
    logic [15:0] m_step = '0;
    logic        m_io = 1'b0;
    logic        m_act = 1'b0;

    function automatic logic [27:0] m_addr();
        return m_base + {8'h0, m_off[27:8]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag);
        logic [27:0] ea;
        logic        twr;
        #1;
        ea  = m_addr();
        twr = m_act && beat && beat_wr && !(tp_en && wdata == tp_val);
        chk({tag, " rd_stb"}, {31'b0, rd_stb}, {31'b0, m_act && beat && !beat_wr});
        chk({tag, " wr_en"}, {31'b0, wr_en}, {31'b0, twr});
        chk({tag, " io_sel now"}, {31'b0, io_sel}, {31'b0, m_act && m_io && ea[15:12] == 4'hD});
        if (load) begin
            m_off = {ld_addr[19:0], 8'h0};
            if (ld_enh) m_base = ({ld_mbyte, 20'h0} + {5'h0, ld_addr[22:20], 20'h0}) & 28'hFF00000;
            else        m_base = {ld_mbyte, 20'h0};
            m_step = {ld_step_int, ld_step_frac};
            m_io   = ld_addr[23];
            m_act  = 1'b1;
        end else if (m_act && beat) begin
            m_off = m_off + {{12{m_step[15]}}, m_step};
        end
        ea = m_addr();
        q.push_back('{a: ea, io: m_act && m_io && ea[15:12] == 4'hD, act: m_act, tag: tag});
    endtask

    task automatic do_load(input logic [23:0] la, input logic [7:0] mb, input logic enh,
                           input logic [15:0] st, input string tag);
        @(negedge clk);
        load = 1'b1; beat = 1'b0; beat_wr = 1'b0;
        ld_addr = la; ld_mbyte = mb; ld_enh = enh;
        ld_step_int = st[15:8]; ld_step_frac = st[7:0];
        apply(tag);
    endtask

    task automatic do_beat(input logic wr, input logic [7:0] wd, input string tag);
        @(negedge clk);
        load = 1'b0; beat = 1'b1; beat_wr = wr; wdata = wd;
        apply(tag);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        load = 1'b0; beat = 1'b0; beat_wr = 1'b0;
        apply(tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " addr"}, {4'h0, addr}, {4'h0, e.a});
            chk({e.tag, " io_sel"}, {31'b0, io_sel}, {31'b0, e.io});
            chk({e.tag, " active"}, {31'b0, active}, {31'b0, e.act});
        end
    end

    bit finished = 1'b0;

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #10;
        chk("R1 reset addr", {4'h0, addr}, 32'h0);
        chk("R1 reset flags", {28'h0, active, io_sel, rd_stb, wr_en}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: beats before any load are ignored
        do_beat(1'b0, 8'h00, "R11 idle read");
        do_beat(1'b1, 8'h55, "R11 idle write");
        // R2 R3: default base, bits 22:20 ignored; R5 R12 byte steps
        do_load(24'h712345, 8'h03, 1'b0, 16'h0100, "R2 R3 load");
        do_beat(1'b0, 8'h00, "R5 R12 step1");
        do_beat(1'b0, 8'h00, "R5 R12 step2");
        // R5: half-byte step
        do_load(24'h000100, 8'h01, 1'b0, 16'h0080, "R5 load half");
        do_beat(1'b0, 8'h00, "R5 half a");
        do_beat(1'b0, 8'h00, "R5 half b");
        do_beat(1'b0, 8'h00, "R5 half c");
        // R6: zero step
        do_load(24'h00ABCD, 8'h02, 1'b0, 16'h0000, "R6 load");
        do_beat(1'b0, 8'h00, "R6 hold a");
        do_beat(1'b1, 8'h11, "R6 hold b");
        // R7: negative wrap
        do_load(24'h000000, 8'h04, 1'b0, 16'hFF00, "R7 load");
        do_beat(1'b0, 8'h00, "R7 wrap down");
        do_beat(1'b0, 8'h00, "R7 down again");
        // R8: positive wrap
        do_load(24'h0FFFFF, 8'h05, 1'b0, 16'h0100, "R8 load");
        do_beat(1'b0, 8'h00, "R8 wrap up");
        // R4: enhanced base, plain and overflowing
        do_load(24'h500010, 8'h02, 1'b1, 16'h0100, "R4 enh sum");
        do_load(24'h700000, 8'hFF, 1'b1, 16'h0100, "R4 enh overflow");
        // R9: I/O window entry and exit
        do_load(24'h80CFFF, 8'h00, 1'b0, 16'h0100, "R9 load io");
        do_beat(1'b0, 8'h00, "R9 enter window");
        do_beat(1'b0, 8'h00, "R9 inside window");
        do_load(24'h80DFFF, 8'h00, 1'b0, 16'h0100, "R9 load edge");
        do_beat(1'b0, 8'h00, "R9 leave window");
        do_load(24'h00D000, 8'h00, 1'b0, 16'h0000, "R9 no io flag");
        do_idle("R9 no io idle");
        // R10: transparency
        @(negedge clk); tp_val = 8'h3C; tp_en = 1'b1;
        do_beat(1'b1, 8'h3C, "R10 match blocked");
        do_beat(1'b1, 8'h3D, "R10 differ passes");
        @(negedge clk); tp_en = 1'b0;
        do_beat(1'b1, 8'h3C, "R10 compare off");
        do_idle("R12 idle");
        do_idle("end");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule